// File: doc/BRIEF.md
# Prioritized Masked Interrupt Controller

This block collects 42 interrupt sources for a small processor core: two internal fault sources, 32 external I/O lines, four I/O channel interrupts, and four miscellaneous sources. These are search/move, real-time clock, manual, and associated processor. A rising edge on any request sets a pending bit for that source. A software-written mask and a global enable decide which pending sources may interrupt. A fixed priority encoder picks the lowest-numbered active source. It presents that source as a 6-bit index, numbered 1 to 42, together with a valid flag.

The core drives single-cycle strobes: enable, disable, instruction retired, interrupt taken (ack), sense, clear one channel, and clear all. An enable only takes effect after one more instruction has retired. Taking an interrupt turns the global enable off. A sense strobe lets software read the raw pending status regardless of the mask, and it clears the two fault bits. A per-channel presence vector is captured at reset. The interrupt line of a missing channel always reads as pending, but it can never be unmasked.

Top module: `prio_intc`

## Requirements
- R1: While reset is held, and on the cycle after it is released: irqValid is 0, intEnabled is 0, the mask is all zero, and senseData shows only the bits forced by absent channels.
- R2: A pending bit is set by a 0-to-1 transition of its request, seen at a clock edge. A request that stays high after its bit was cleared does not set the bit again until it falls and rises once more.
- R3: Bit k of senseData and of maskWrData stands for source index k+1. The source indices are as follows. Index 1 is the arithmetic fault and index 2 is the exponent/BCD fault. External line l of channel c is index 3+4*l+c, where that request is ioLineReq bit 8*c+l. Channel interrupt c is index 35+c. Search/move, clock, manual and associated processor are indices 39 to 42, from miscReq bits 0 to 3. irqIndex is the lowest index that is both pending and masked-in.
- R4: irqValid is high exactly when the effective enable is on and at least one pending bit is also set in the mask. While irqValid is low, irqIndex is 0.
- R5: An enableCmd arms the enable. intEnabled rises only after a retirePulse that arrives in a later cycle than the enableCmd. A retirePulse in the same cycle as the enableCmd does not count.
- R6: A disableCmd clears intEnabled on the following cycle. This also applies to an enable that is armed but not yet in effect.
- R7: An ack while irqValid is high clears intEnabled on the following cycle. If the winning source is one of indices 39 to 42, the ack also clears that source's pending bit. No other pending bit changes.
- R8: A senseCmd clears the pending bits of indices 1 and 2. It leaves all other pending bits unchanged.
- R9: A clearChanCmd with clearChanSel = c clears channel interrupt c and the eight external lines of channel c. The other channels are unaffected.
- R10: A clearAllCmd or extClear clears all 32 external line bits and all four channel bits. It leaves the fault bits and the miscellaneous bits unchanged.
- R11: For a channel marked absent, senseData bit 34+c always reads 1. A mask write to that bit is ignored, and that channel never raises irqValid.
- R12: chanPresent is sampled only while reset is held. Changing it afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chanPresent | input | 4 | Per-channel presence, sampled during reset |
| faultReq | input | 2 | Internal fault requests (bit 0: index 1, bit 1: index 2) |
| ioLineReq | input | 32 | External line requests, bit 8*channel+line |
| chanReq | input | 4 | I/O channel interrupt requests |
| miscReq | input | 4 | Search/move, clock, manual, associated processor |
| enableCmd | input | 1 | Enable strobe (delayed effect) |
| disableCmd | input | 1 | Disable strobe |
| retirePulse | input | 1 | One instruction retired |
| ack | input | 1 | Core takes the presented interrupt |
| senseCmd | input | 1 | Sense strobe; clears fault bits |
| clearChanCmd | input | 1 | Clear one channel's interrupts |
| clearChanSel | input | 2 | Channel to clear |
| clearAllCmd | input | 1 | Clear all I/O interrupts |
| extClear | input | 1 | External clear of all I/O interrupts |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrData | input | 42 | New mask, bit k = index k+1 |
| senseData | output | 42 | Raw pending status, absent channels forced to 1 |
| irqValid | output | 1 | An interrupt is being presented |
| irqIndex | output | 6 | Winning source index 1..42, 0 when idle |
| intEnabled | output | 1 | Effective global enable |

## Verification
A pending bit in the wrong state shows up on senseData at the next sample, and on irqIndex as soon as the source is masked in and enabled. An error in the enable sequencer shows up on intEnabled one edge after the faulty strobe, and from there on irqValid. Errors in the priority mapping appear only when two sources are pending at once. For that reason, the tests pair sources that sit close together in the interleaved order. A lost clear stays visible on senseData until the next reset, so each clear is followed by a sense sample on the very next cycle.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  localparam int DEF_FAULTS = 2;
  localparam int DEF_CHANS  = 4;
  localparam int DEF_LINES  = 8;
  localparam int DEF_MISC   = 4;

  // Global enable sequencer states
  typedef enum logic [1:0] {
    EN_OFF   = 2'd0,
    EN_ARMED = 2'd1,
    EN_ON    = 2'd2
  } enState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic senseClr;
    logic chanClr;
    logic allClr;
    logic takeClr;
    logic maskWr;
  } dpStrobes_t;

endpackage

// File: rtl/prio_intc_enc.sv
module prio_intc_enc #(
  parameter int N     = 42,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     reqs,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest set bit wins; index is reported one-based
  always_comb begin
    found = |reqs;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (reqs[k]) idx = IDX_W'(k + 1);
    end
  end

endmodule

// File: rtl/prio_intc_dp.sv
module prio_intc_dp
  import prio_intc_pkg::*;
#(
  parameter int NUM_FAULT = DEF_FAULTS,
  parameter int NUM_CHAN  = DEF_CHANS,
  parameter int LINES     = DEF_LINES,
  parameter int NUM_MISC  = DEF_MISC,
  localparam int NUM_IO    = NUM_CHAN * LINES,
  localparam int CHAN_BASE = NUM_FAULT + NUM_IO,
  localparam int MISC_BASE = CHAN_BASE + NUM_CHAN,
  localparam int NUM_SRC   = MISC_BASE + NUM_MISC,
  localparam int IDX_W     = $clog2(NUM_SRC + 1),
  localparam int SEL_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CHAN-1:0]  chanPresent,
  input  logic [NUM_FAULT-1:0] faultReq,
  input  logic [NUM_IO-1:0]    ioLineReq,
  input  logic [NUM_CHAN-1:0]  chanReq,
  input  logic [NUM_MISC-1:0]  miscReq,
  input  dpStrobes_t           strobes,
  input  logic [SEL_W-1:0]     clearChanSel,
  input  logic [NUM_SRC-1:0]   maskWrData,
  output logic [NUM_SRC-1:0]   senseData,
  output logic                 anyActive,
  output logic [IDX_W-1:0]     winIdx
);

  logic [NUM_SRC-1:0]  reqVec;
  logic [NUM_SRC-1:0]  reqPrev;
  logic [NUM_SRC-1:0]  pendReg;
  logic [NUM_SRC-1:0]  maskReg;
  logic [NUM_SRC-1:0]  absentVec;
  logic [NUM_SRC-1:0]  clrVec;
  logic [NUM_SRC-1:0]  activeVec;
  logic [NUM_CHAN-1:0] presentReg;

  // Gather requests into priority order (bit k = index k+1)
  assign reqVec[NUM_FAULT-1:0]            = faultReq;
  assign reqVec[CHAN_BASE +: NUM_CHAN]    = chanReq;
  assign reqVec[MISC_BASE +: NUM_MISC]    = miscReq;

  // External lines interleaved line-major across channels
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    for (genvar l = 0; l < LINES; l++) begin : g_line
      assign reqVec[NUM_FAULT + l*NUM_CHAN + c] = ioLineReq[c*LINES + l];
    end
  end

  // Absent channels: forced pending on sense, never maskable
  always_comb begin
    absentVec = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      absentVec[CHAN_BASE + c] = !presentReg[c];
    end
  end

  // Clear vector from control strobes
  always_comb begin
    clrVec = '0;
    if (strobes.senseClr) begin
      for (int k = 0; k < NUM_FAULT; k++) clrVec[k] = 1'b1;
    end
    if (strobes.allClr) begin
      for (int k = NUM_FAULT; k < MISC_BASE; k++) clrVec[k] = 1'b1;
    end
    if (strobes.chanClr) begin
      for (int c = 0; c < NUM_CHAN; c++) begin
        if (clearChanSel == SEL_W'(c)) begin
          clrVec[CHAN_BASE + c] = 1'b1;
          for (int l = 0; l < LINES; l++) clrVec[NUM_FAULT + l*NUM_CHAN + c] = 1'b1;
        end
      end
    end
    if (strobes.takeClr) begin
      for (int k = MISC_BASE; k < NUM_SRC; k++) begin
        if (winIdx == IDX_W'(k + 1)) clrVec[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      presentReg <= chanPresent;
      reqPrev    <= '0;
      pendReg    <= '0;
      maskReg    <= '0;
    end else begin
      reqPrev <= reqVec;
      // A new edge in the same cycle as a clear keeps the bit set
      pendReg <= (pendReg & ~clrVec) | (reqVec & ~reqPrev);
      if (strobes.maskWr) maskReg <= maskWrData & ~absentVec;
    end
  end

  assign senseData = pendReg | absentVec;
  assign activeVec = pendReg & maskReg;

  prio_intc_enc #(
    .N     (NUM_SRC),
    .IDX_W (IDX_W)
  ) u_enc (
    .reqs  (activeVec),
    .found (anyActive),
    .idx   (winIdx)
  );

endmodule

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enableCmd,
  input  logic       disableCmd,
  input  logic       retirePulse,
  input  logic       ack,
  input  logic       senseCmd,
  input  logic       clearChanCmd,
  input  logic       clearAllCmd,
  input  logic       extClear,
  input  logic       maskWrEn,
  input  logic       anyActive,
  output dpStrobes_t strobes,
  output logic       irqValid,
  output logic       intEnabled
);

  enState_t enState;
  enState_t enNext;

  assign intEnabled = (enState == EN_ON);
  assign irqValid   = intEnabled && anyActive;

  always_comb begin
    enNext = enState;
    if (disableCmd || (ack && irqValid)) begin
      enNext = EN_OFF;
    end else if (enableCmd) begin
      enNext = (enState == EN_ON) ? EN_ON : EN_ARMED;
    end else if (enState == EN_ARMED && retirePulse) begin
      enNext = EN_ON;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) enState <= EN_OFF;
    else     enState <= enNext;
  end

  always_comb begin
    strobes.senseClr = senseCmd;
    strobes.chanClr  = clearChanCmd;
    strobes.allClr   = clearAllCmd || extClear;
    strobes.takeClr  = ack && irqValid;
    strobes.maskWr   = maskWrEn;
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_FAULT = DEF_FAULTS,
  parameter int NUM_CHAN  = DEF_CHANS,
  parameter int LINES     = DEF_LINES,
  parameter int NUM_MISC  = DEF_MISC,
  localparam int NUM_IO    = NUM_CHAN * LINES,
  localparam int NUM_SRC   = NUM_FAULT + NUM_IO + NUM_CHAN + NUM_MISC,
  localparam int IDX_W     = $clog2(NUM_SRC + 1),
  localparam int SEL_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CHAN-1:0]  chanPresent,
  input  logic [NUM_FAULT-1:0] faultReq,
  input  logic [NUM_IO-1:0]    ioLineReq,
  input  logic [NUM_CHAN-1:0]  chanReq,
  input  logic [NUM_MISC-1:0]  miscReq,
  input  logic                 enableCmd,
  input  logic                 disableCmd,
  input  logic                 retirePulse,
  input  logic                 ack,
  input  logic                 senseCmd,
  input  logic                 clearChanCmd,
  input  logic [SEL_W-1:0]     clearChanSel,
  input  logic                 clearAllCmd,
  input  logic                 extClear,
  input  logic                 maskWrEn,
  input  logic [NUM_SRC-1:0]   maskWrData,
  output logic [NUM_SRC-1:0]   senseData,
  output logic                 irqValid,
  output logic [IDX_W-1:0]     irqIndex,
  output logic                 intEnabled
);

  dpStrobes_t           strobes;
  logic                 anyActive;
  logic [IDX_W-1:0]     winIdx;

  prio_intc_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .enableCmd    (enableCmd),
    .disableCmd   (disableCmd),
    .retirePulse  (retirePulse),
    .ack          (ack),
    .senseCmd     (senseCmd),
    .clearChanCmd (clearChanCmd),
    .clearAllCmd  (clearAllCmd),
    .extClear     (extClear),
    .maskWrEn     (maskWrEn),
    .anyActive    (anyActive),
    .strobes      (strobes),
    .irqValid     (irqValid),
    .intEnabled   (intEnabled)
  );

  prio_intc_dp #(
    .NUM_FAULT (NUM_FAULT),
    .NUM_CHAN  (NUM_CHAN),
    .LINES     (LINES),
    .NUM_MISC  (NUM_MISC)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .chanPresent  (chanPresent),
    .faultReq     (faultReq),
    .ioLineReq    (ioLineReq),
    .chanReq      (chanReq),
    .miscReq      (miscReq),
    .strobes      (strobes),
    .clearChanSel (clearChanSel),
    .maskWrData   (maskWrData),
    .senseData    (senseData),
    .anyActive    (anyActive),
    .winIdx       (winIdx)
  );

  assign irqIndex = irqValid ? winIdx : '0;

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NUM_CHAN  = 4,
  parameter int NUM_SRC   = 42,
  parameter int CHAN_BASE = 34,
  parameter int IDX_W     = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CHAN-1:0] chanPresent,
  input logic               faultReq0,
  input logic               enableCmd,
  input logic               disableCmd,
  input logic               ack,
  input logic               senseCmd,
  input logic [NUM_SRC-1:0] senseData,
  input logic               irqValid,
  input logic [IDX_W-1:0]   irqIndex,
  input logic               intEnabled
);

  logic [NUM_CHAN-1:0] presSeen;

  always_ff @(posedge clk) begin
    if (rst) presSeen <= chanPresent;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!intEnabled && !irqValid));

  // R3
  index_range_chk: assert property (@(posedge clk) disable iff (rst)
    irqValid |-> (irqIndex >= IDX_W'(1) && irqIndex <= IDX_W'(NUM_SRC)));

  // R4
  valid_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irqValid |-> intEnabled);

  // R5
  enable_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (enableCmd && !disableCmd && !intEnabled) |=> !intEnabled);

  // R6
  disable_now_chk: assert property (@(posedge clk) disable iff (rst)
    disableCmd |=> !intEnabled);

  // R7
  ack_disables_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && irqValid) |=> !intEnabled);

  // R8
  sense_clears_fault_chk: assert property (@(posedge clk) disable iff (rst)
    senseCmd |=> (!senseData[0] || faultReq0));

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_abs
    // R11
    absent_reads_chk: assert property (@(posedge clk) disable iff (rst)
      !presSeen[c] |-> senseData[CHAN_BASE + c]);
    // R11
    absent_silent_chk: assert property (@(posedge clk) disable iff (rst)
      (!presSeen[c] && irqValid) |-> (irqIndex != IDX_W'(CHAN_BASE + c + 1)));
  end

endmodule

bind prio_intc prio_intc_chk #(
  .NUM_CHAN  (NUM_CHAN),
  .NUM_SRC   (NUM_SRC),
  .CHAN_BASE (NUM_FAULT + NUM_IO),
  .IDX_W     (IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .chanPresent (chanPresent),
  .faultReq0   (faultReq[0]),
  .enableCmd   (enableCmd),
  .disableCmd  (disableCmd),
  .ack         (ack),
  .senseCmd    (senseCmd),
  .senseData   (senseData),
  .irqValid    (irqValid),
  .irqIndex    (irqIndex),
  .intEnabled  (intEnabled)
);

// File: tb/prio_intc_bench.sv
`timescale 1ns/1ps
module prio_intc_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  chanPresent;
  logic [1:0]  faultReq;
  logic [31:0] ioLineReq;
  logic [3:0]  chanReq;
  logic [3:0]  miscReq;
  logic        enableCmd, disableCmd, retirePulse, ack, senseCmd;
  logic        clearChanCmd, clearAllCmd, extClear, maskWrEn;
  logic [1:0]  clearChanSel;
  logic [41:0] maskWrData;
  logic [41:0] senseData;
  logic        irqValid;
  logic [5:0]  irqIndex;
  logic        intEnabled;

  int checks = 0;
  int fails  = 0;
  localparam logic [41:0] ALL_ONES = {42{1'b1}};

  always #10 clk = ~clk;

  prio_intc u_prio_intc (
    .clk(clk), .rst(rst), .chanPresent(chanPresent), .faultReq(faultReq),
    .ioLineReq(ioLineReq), .chanReq(chanReq), .miscReq(miscReq),
    .enableCmd(enableCmd), .disableCmd(disableCmd), .retirePulse(retirePulse),
    .ack(ack), .senseCmd(senseCmd), .clearChanCmd(clearChanCmd),
    .clearChanSel(clearChanSel), .clearAllCmd(clearAllCmd), .extClear(extClear),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .senseData(senseData),
    .irqValid(irqValid), .irqIndex(irqIndex), .intEnabled(intEnabled)
  );

  // Index of external line l on channel c, and its sense bit
  function automatic int ioIdx(int c, int l);
    return 3 + 4*l + c;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; chanPresent = 4'b0111;
    faultReq = '0; ioLineReq = '0; chanReq = '0; miscReq = '0;
    enableCmd = 0; disableCmd = 0; retirePulse = 0; ack = 0; senseCmd = 0;
    clearChanCmd = 0; clearChanSel = '0; clearAllCmd = 0; extClear = 0;
    maskWrEn = 0; maskWrData = '0;
    tick(); tick();
    rst = 1'b0;
    chanPresent = 4'b1111;  // R12: ignored after reset
  endtask

  task automatic writeMask(input logic [41:0] m);
    maskWrEn = 1; maskWrData = m; tick(); maskWrEn = 0;
  endtask

  task automatic enableNow();
    enableCmd = 1; tick(); enableCmd = 0;
    retirePulse = 1; tick(); retirePulse = 0;
  endtask

  task automatic testReset();
    doReset();
    check("R1 irqValid", 64'(irqValid), 64'd0);
    check("R1 intEnabled", 64'(intEnabled), 64'd0);
    check("R1 senseData", 64'(senseData), 64'(42'd1 << 37));
    enableNow();
    ioLineReq[0] = 1; tick();
    check("R1 mask clear blocks irq", 64'(irqValid), 64'd0);
  endtask

  task automatic testEdge();
    doReset();
    ioLineReq[3] = 1; tick();
    check("R2 edge sets", 64'(senseData[ioIdx(0,3)-1]), 64'd1);
    clearAllCmd = 1; tick(); clearAllCmd = 0;
    tick(); tick();
    check("R2 held level no reset", 64'(senseData[ioIdx(0,3)-1]), 64'd0);
    ioLineReq[3] = 0; tick(); ioLineReq[3] = 1; tick();
    check("R2 new edge sets", 64'(senseData[ioIdx(0,3)-1]), 64'd1);
  endtask

  task automatic testPriority();
    doReset();
    writeMask(ALL_ONES);
    enableNow();
    ioLineReq[8*2+0] = 1; ioLineReq[8*0+1] = 1; tick();
    check("R3 sense bit ch2 l0", 64'(senseData[4]), 64'd1);
    check("R3 sense bit ch0 l1", 64'(senseData[6]), 64'd1);
    check("R3 line-major winner", 64'(irqIndex), 64'(ioIdx(2,0)));
    chanReq[1] = 1; miscReq[0] = 1; tick();
    check("R3 io over chan/misc", 64'(irqIndex), 64'd5);
    faultReq[1] = 1; tick();
    check("R3 fault2 wins", 64'(irqIndex), 64'd2);
    faultReq[0] = 1; tick();
    check("R3 fault1 wins", 64'(irqIndex), 64'd1);
  endtask

  task automatic testMask();
    doReset();
    writeMask(ALL_ONES);
    faultReq[1] = 1; ioLineReq[8*2+0] = 1; ioLineReq[8*0+1] = 1; tick();
    check("R4 pending but disabled", 64'(irqValid), 64'd0);
    check("R4 idle index zero", 64'(irqIndex), 64'd0);
    enableNow();
    check("R4 valid when enabled", 64'(irqValid), 64'd1);
    writeMask(ALL_ONES & ~(42'd1 << 1) & ~(42'd1 << 4));
    check("R4 masked skip", 64'(irqIndex), 64'd7);
    writeMask('0);
    check("R4 all masked", 64'(irqValid), 64'd0);
  endtask

  task automatic testEnableDelay();
    doReset();
    enableCmd = 1; retirePulse = 1; tick(); enableCmd = 0; retirePulse = 0;
    check("R5 same-cycle retire ignored", 64'(intEnabled), 64'd0);
    tick();
    check("R5 waits for retire", 64'(intEnabled), 64'd0);
    retirePulse = 1; tick(); retirePulse = 0;
    check("R5 on after retire", 64'(intEnabled), 64'd1);
  endtask

  task automatic testDisable();
    doReset();
    enableNow();
    disableCmd = 1; tick(); disableCmd = 0;
    check("R6 disable immediate", 64'(intEnabled), 64'd0);
    enableCmd = 1; tick(); enableCmd = 0;
    disableCmd = 1; tick(); disableCmd = 0;
    retirePulse = 1; tick(); retirePulse = 0;
    check("R6 disable cancels armed", 64'(intEnabled), 64'd0);
  endtask

  task automatic testAck();
    doReset();
    writeMask(ALL_ONES);
    enableNow();
    miscReq[2] = 1; miscReq[3] = 1; tick();
    check("R7 manual presented", 64'(irqIndex), 64'd41);
    ack = 1; tick(); ack = 0;
    check("R7 ack disables", 64'(intEnabled), 64'd0);
    check("R7 no irq after ack", 64'(irqValid), 64'd0);
    check("R7 winner cleared", 64'(senseData[40]), 64'd0);
    check("R7 other kept", 64'(senseData[41]), 64'd1);
  endtask

  task automatic testSense();
    doReset();
    faultReq = 2'b11; ioLineReq[0] = 1; tick();
    check("R8 faults pending", 64'(senseData[1:0]), 64'd3);
    senseCmd = 1; tick(); senseCmd = 0;
    check("R8 faults cleared", 64'(senseData[1:0]), 64'd0);
    check("R8 io kept", 64'(senseData[2]), 64'd1);
  endtask

  task automatic testClearChan();
    doReset();
    ioLineReq[8*1+3] = 1; ioLineReq[8*2+3] = 1; chanReq[1] = 1; chanReq[2] = 1; tick();
    clearChanSel = 2'd1; clearChanCmd = 1; tick(); clearChanCmd = 0;
    check("R9 ch1 line cleared", 64'(senseData[ioIdx(1,3)-1]), 64'd0);
    check("R9 ch1 chan cleared", 64'(senseData[35]), 64'd0);
    check("R9 ch2 line kept", 64'(senseData[ioIdx(2,3)-1]), 64'd1);
    check("R9 ch2 chan kept", 64'(senseData[36]), 64'd1);
  endtask

  task automatic testClearAll();
    doReset();
    faultReq[0] = 1; ioLineReq[5] = 1; chanReq[0] = 1; miscReq[0] = 1; tick();
    clearAllCmd = 1; tick(); clearAllCmd = 0;
    check("R10 clear-all", 64'(senseData), 64'((42'd1 << 0) | (42'd1 << 38) | (42'd1 << 37)));
    ioLineReq[9] = 1; tick();
    check("R10 new io set", 64'(senseData[ioIdx(1,1)-1]), 64'd1);
    extClear = 1; tick(); extClear = 0;
    check("R10 external clear", 64'(senseData[ioIdx(1,1)-1]), 64'd0);
  endtask

  task automatic testAbsent();
    doReset();
    check("R11 absent reads pending", 64'(senseData[37]), 64'd1);
    writeMask(ALL_ONES);
    enableNow();
    chanReq[3] = 1; tick();
    check("R12 late config ignored, no irq", 64'(irqValid), 64'd0);
    check("R11 still reads pending", 64'(senseData[37]), 64'd1);
    chanReq[0] = 1; tick();
    check("R11 present channel works", 64'(irqIndex), 64'd35);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    testReset();
    testEdge();
    testPriority();
    testMask();
    testEnableDelay();
    testDisable();
    testAck();
    testSense();
    testClearChan();
    testClearAll();
    testAbsent();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule